// File: doc/BRIEF.md
# Counter-Sequenced Three-Bit Toy Processor

This block is a minimal teaching processor. Its program, its operands and its opcodes all sit in one store of sixteen 3-bit words. A free-running 4-bit step counter picks one word per clock through a one-hot select. That word is the only one placed on a shared bus. An opcode decoder reads the bus word and raises one operation strobe. A route flag decides what the bus word means. In the opcode position the word is decoded. In the data position the word is written into working register A or B.

A LOAD opcode turns the route flag to the data position, so the word that follows is treated as an operand and is never decoded. Arithmetic and logic results land in register C. Two move operations copy C back into A or B. The store is filled through a preload port while reset is held. Once reset is released, the counter runs the program one word per clock.

Top module: `toy3_core`

## Requirements
- R1: During reset `step_idx` is 0. After reset is released it rises by exactly one on each clock and wraps from 15 to 0.
- R2: `bus_word` always shows the stored word whose index equals `step_idx`.
- R3: Opcode encoding is 000 = copy C to A, 001 = copy C to B, 010 = ADD, 011 = SUB, 100 = AND, 101 = OR, 110 = LOAD A, 111 = LOAD B.
- R4: A LOAD opcode on the bus sets `route_data` to 1 on the next clock. On the clock after that, the bus word is written into the LOAD's target register without being decoded, and `route_data` returns to 0.
- R5: With `route_data` at 0, ADD, SUB (A minus B), AND and OR write their result, modulo 8, into C. A and B stay unchanged.
- R6: With `route_data` at 0, opcode 000 copies C into A and opcode 001 copies C into B.
- R7: Synchronous reset clears the counter and registers A, B and C, and sets `route_data` to 0. The stored words keep their contents.
- R8: While `rst` is high, `pre_we` writes `pre_data` into word `pre_addr`. While `rst` is low, `pre_we` has no effect.
- R9: The program LOAD A, 5, LOAD B, 2, ADD in words 0 to 4 leaves C = 7 after five clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also opens the preload port |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | 4 | Preload word index |
| pre_data | input | 3 | Preload word value |
| step_idx | output | 4 | Current step counter value |
| bus_word | output | 3 | Word currently driven on the shared bus |
| reg_a | output | 3 | Working register A |
| reg_b | output | 3 | Working register B |
| reg_c | output | 3 | Result register C |
| route_data | output | 1 | 1 when the next bus word is data for A or B |

## Verification
A table of operand pairs runs each ALU operation through the same LOAD A, LOAD B, operate program. The pairs cover an ADD that wraps past 7, SUBs that borrow and SUBs that do not, and AND/OR masks whose results differ from one another. A directed program places the LOAD A opcode value as a data word, which shows whether the route flag really suppresses decoding. In the same program, SUB, the two copy operations and ADD are chained, so results that are wrongly routed between A, B and C show up. Further runs write to the preload port mid-program, reset in the middle of a run, and run the counter through its wrap. These separate store protection, register clearing and counter overflow from one another.

// File: rtl/toy3_pkg.sv
package toy3_pkg;
    localparam int WORD_W = 3;
    localparam int ADDR_W = 4;

    typedef enum logic [WORD_W-1:0] {
        OP_MOVA = 3'd0,
        OP_MOVB = 3'd1,
        OP_ADD  = 3'd2,
        OP_SUB  = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_LDA  = 3'd6,
        OP_LDB  = 3'd7
    } op_e;

    typedef enum logic {
        DST_A = 1'b0,
        DST_B = 1'b1
    } dst_e;

    typedef struct packed {
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
        logic [WORD_W-1:0] c;
    } work_t;

    function automatic logic is_alu_op(input op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) || (op == OP_OR);
    endfunction
endpackage

// File: rtl/toy3_stepper.sv
module toy3_stepper #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    assert_step_inc_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cnt == ADDR_W'($past(cnt) + 1'b1));
endmodule

// File: rtl/toy3_store.sv
module toy3_store #(
    parameter int WORD_W = 3,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [WORD_W-1:0] pre_data,
    input  logic [ADDR_W-1:0] sel_addr,
    output logic [WORD_W-1:0] bus
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  sel;

    for (genvar i = 0; i < DEPTH; i++) begin : g_sel
        assign sel[i] = (sel_addr == ADDR_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst && pre_we) mem[pre_addr] <= pre_data;
    end

    always_comb begin
        bus = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sel[i]) bus = bus | mem[i];
        end
    end

    assert_one_word_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(sel) == 1);
endmodule

// File: rtl/toy3_opdec.sv
module toy3_opdec
    import toy3_pkg::*;
(
    input  logic              en,
    input  logic [WORD_W-1:0] word,
    output logic [7:0]        strobe
);
    always_comb begin
        strobe = '0;
        if (en) strobe[word] = 1'b1;
    end
endmodule

// File: rtl/toy3_alu.sv
module toy3_alu
    import toy3_pkg::*;
(
    input  op_e               op,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] y
);
    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/toy3_core.sv
module toy3_core
    import toy3_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [WORD_W-1:0] pre_data,
    output logic [ADDR_W-1:0] step_idx,
    output logic [WORD_W-1:0] bus_word,
    output logic [WORD_W-1:0] reg_a,
    output logic [WORD_W-1:0] reg_b,
    output logic [WORD_W-1:0] reg_c,
    output logic              route_data
);
    work_t             wr;
    logic              route_q;
    dst_e              dst_q;
    logic [7:0]        strobe;
    logic [WORD_W-1:0] alu_y;
    op_e               bus_op;

    assign bus_op = op_e'(bus_word);

    toy3_stepper #(.ADDR_W(ADDR_W)) u_step (
        .clk (clk),
        .rst (rst),
        .cnt (step_idx)
    );

    toy3_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .pre_we   (pre_we),
        .pre_addr (pre_addr),
        .pre_data (pre_data),
        .sel_addr (step_idx),
        .bus      (bus_word)
    );

    toy3_opdec u_dec (
        .en     (!route_q),
        .word   (bus_word),
        .strobe (strobe)
    );

    toy3_alu u_alu (
        .op (bus_op),
        .a  (wr.a),
        .b  (wr.b),
        .y  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr      <= '0;
            route_q <= 1'b0;
            dst_q   <= DST_A;
        end else if (route_q) begin
            if (dst_q == DST_A) wr.a <= bus_word;
            else                wr.b <= bus_word;
            route_q <= 1'b0;
        end else begin
            if (strobe[OP_LDA]) begin
                route_q <= 1'b1;
                dst_q   <= DST_A;
            end
            if (strobe[OP_LDB]) begin
                route_q <= 1'b1;
                dst_q   <= DST_B;
            end
            if (strobe[OP_ADD] || strobe[OP_SUB] || strobe[OP_AND] || strobe[OP_OR])
                wr.c <= alu_y;
            if (strobe[OP_MOVA]) wr.a <= wr.c;
            if (strobe[OP_MOVB]) wr.b <= wr.c;
        end
    end

    assign reg_a      = wr.a;
    assign reg_b      = wr.b;
    assign reg_c      = wr.c;
    assign route_data = route_q;

    assert_route_clears_R4: assert property (@(posedge clk) disable iff (rst)
        route_data |=> !route_data);

    assert_load_sets_route_R4: assert property (@(posedge clk) disable iff (rst)
        (!route_data && (bus_word == OP_LDA || bus_word == OP_LDB)) |=> route_data);

    assert_add_result_R5: assert property (@(posedge clk) disable iff (rst)
        (!route_data && bus_word == OP_ADD) |=> reg_c == WORD_W'($past(reg_a) + $past(reg_b)));

    assert_alu_keeps_ab_R5: assert property (@(posedge clk) disable iff (rst)
        (!route_data && is_alu_op(bus_op)) |=> ($stable(reg_a) && $stable(reg_b)));

    assert_mova_copy_R6: assert property (@(posedge clk) disable iff (rst)
        (!route_data && bus_word == OP_MOVA) |=> reg_a == $past(reg_c));
endmodule

// File: tb/tb_toy3_core.sv
module tb_toy3_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pre_we = 1'b0;
    logic [3:0] pre_addr = '0;
    logic [2:0] pre_data = '0;
    logic [3:0] step_idx;
    logic [2:0] bus_word, reg_a, reg_b, reg_c;
    logic       route_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [2:0] prog [16];

    always #2 clk = ~clk;

    toy3_core dut (
        .clk(clk), .rst(rst), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
        .step_idx(step_idx), .bus_word(bus_word), .reg_a(reg_a), .reg_b(reg_b),
        .reg_c(reg_c), .route_data(route_data)
    );

    // {a, b, opcode, expected C}
    localparam logic [11:0] VEC [8] = '{
        {3'd5, 3'd2, 3'd2, 3'd7},
        {3'd7, 3'd1, 3'd2, 3'd0},
        {3'd3, 3'd5, 3'd3, 3'd6},
        {3'd5, 3'd3, 3'd3, 3'd2},
        {3'd6, 3'd3, 3'd4, 3'd2},
        {3'd5, 3'd2, 3'd5, 3'd7},
        {3'd4, 3'd4, 3'd3, 3'd0},
        {3'd6, 3'd5, 3'd4, 3'd4}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_prog();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 16; i++) begin
            pre_we = 1'b1; pre_addr = 4'(i); pre_data = prog[i];
            @(negedge clk);
        end
        pre_we = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic steps(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: five plus two, checked step by step
        for (int i = 0; i < 16; i++) prog[i] = 3'b001;
        prog[0] = 3'b110; prog[1] = 3'b101; prog[2] = 3'b111; prog[3] = 3'b010; prog[4] = 3'b010;
        load_prog();
        chk("R7 reset step", step_idx, 0);
        chk("R7 reset A", reg_a, 0);
        chk("R7 reset B", reg_b, 0);
        chk("R7 reset C", reg_c, 0);
        chk("R7 reset route", route_data, 0);
        chk("R2 bus word0", bus_word, 6);
        steps(1);
        chk("R1 step after one", step_idx, 1);
        chk("R4 route set", route_data, 1);
        chk("R2 bus word1", bus_word, 5);
        steps(1);
        chk("R4 A loaded", reg_a, 5);
        chk("R4 route cleared", route_data, 0);
        steps(3);
        chk("R9 sum C", reg_c, 7);

        // R3 R5: table of ALU vectors
        for (int v = 0; v < 8; v++) begin
            for (int i = 0; i < 16; i++) prog[i] = 3'b001;
            prog[0] = 3'b110; prog[1] = VEC[v][11:9];
            prog[2] = 3'b111; prog[3] = VEC[v][8:6];
            prog[4] = VEC[v][5:3];
            load_prog();
            steps(5);
            chk("R5 alu C", reg_c, VEC[v][2:0]);
            chk("R5 A kept", reg_a, VEC[v][11:9]);
            chk("R5 B kept", reg_b, VEC[v][8:6]);
        end

        // R4 R6 R8 R1: data word equal to LOAD A, copies, protected store, wrap
        prog[0] = 3'b110; prog[1] = 3'b011; prog[2] = 3'b111; prog[3] = 3'b110;
        prog[4] = 3'b011; prog[5] = 3'b000; prog[6] = 3'b001; prog[7] = 3'b010;
        for (int i = 8; i < 16; i++) prog[i] = 3'b001;
        load_prog();
        steps(4);
        chk("R4 data not decoded", route_data, 0);
        chk("R4 B loaded", reg_b, 6);
        steps(1);
        chk("R5 sub wrap C", reg_c, 5);
        steps(1);
        chk("R6 copy to A", reg_a, 5);
        pre_we = 1'b1; pre_addr = 4'd7; pre_data = 3'b101;
        steps(1);
        pre_we = 1'b0;
        chk("R6 copy to B", reg_b, 5);
        chk("R8 preload ignored", bus_word, 2);
        steps(1);
        chk("R5 add after copies", reg_c, 2);
        steps(8);
        chk("R1 wrap to zero", step_idx, 0);
        chk("R6 B from C", reg_b, 2);

        // R7 R8: mid-run reset keeps the store
        load_prog();
        steps(3);
        rst = 1'b1;
        steps(1);
        chk("R7 midrun A", reg_a, 0);
        chk("R7 midrun B", reg_b, 0);
        chk("R7 midrun step", step_idx, 0);
        chk("R7 midrun route", route_data, 0);
        chk("R8 store kept", bus_word, 6);
        rst = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule